// File: doc/BRIEF.md
# Static Memory Read/Write Timing Sequencer

This block drives the control strobes for asynchronous static devices on a shared data bus: plain ROM or flash, ROM or flash that bursts in groups of four or eight words, and I/O devices with variable latency. A request port accepts a chip-select index, a word address, a read/write flag, a beat count and write data. The block then asserts one active-low chip select, presents an address for each beat and holds output enable (reads) or write enable (writes) low for a number of memory clocks. That number comes from a configuration word owned by that chip select.

Each chip select has a 14-bit configuration word. It holds a device class code, a first-access latency, a follow-on latency and a bus-release count. Word i of `cfg_words` sits at bits [14i+13:14i]. Read data is captured at the end of each beat window and returned with a single-cycle valid strobe. A done strobe marks the end of every access. Variable-latency devices can stretch the strobe by holding a not-ready input low. When a new access goes to a different chip select, the block inserts an idle gap so the previous device can release the bus. A new access to the same chip select follows without that gap.

Top module: `srom_seq`

## Requirements
- R1: After synchronous reset, every `mem_cs_n` bit, `mem_oe_n` and `mem_we_n` are high, `rsp_valid`, `rsp_done` and `mem_wdata_en` are low, and `req_ready` is high.
- R2: The class code sits in configuration bits [2:0], the first latency F in [6:3], the follow-on latency N in [10:7] and the release count C in [13:11]. For class 0 and for the unused codes 1, 5, 6 and 7, every read beat keeps `mem_oe_n` low for F+1 clocks.
- R3: For class 2 (groups of four), read beats whose index is a multiple of 4 last F+1 clocks and all other beats last N+1 clocks. An 8-beat read therefore pays F+1 again at beat 4.
- R4: For class 3 (groups of eight), beat 0 lasts F+1 clocks and beats 1 to 7 each last N+1 clocks.
- R5: During a read, exactly one chip select is low. `mem_addr` equals the request address plus the beat index. `req_len` is the beat count minus one. The data on `mem_rdata` in the last clock of a beat appears on `rsp_data` with `rsp_valid` high in the following clock.
- R6: For class codes other than 4, a write is one beat whatever `req_len` says. Chip select, address, write data with `mem_wdata_en` high, and `mem_we_n` low all start in the same clock, and `mem_we_n` stays low for F+1 clocks.
- R7: For class 4, the strobe (`mem_oe_n` or `mem_we_n`) stays low for F+1+W clocks. W counts the clocks from the (F+1)th strobe clock onward in which `mem_wait_n` was sampled low. The strobe then stays high for N+1 clocks while chip select and address are held. A read's data is captured in the last strobe clock.
- R8: `mem_wait_n` has no effect on the timing of classes other than 4.
- R9: `rsp_done` pulses for one clock in the first clock after the chip select rises. For reads of classes other than 4, this is the same clock as the last `rsp_valid`.
- R10: After an access, `req_ready` stays low for a request to a different chip select while the release count runs. All chip selects therefore stay high for at least C+1 clocks, where C is the count of the finished device.
- R11: A request to the same chip select as the previous access is accepted in the first clock after its chip select rises, without the release gap.
- R12: `req_ready` is low while an access is in progress. A request is accepted only in a clock where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | NUM_CS*14 | Per-chip-select configuration words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_cs | input | log2(NUM_CS) | Target chip select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of beat 0 |
| req_len | input | LEN_W | Beat count minus one |
| req_wdata | input | DATA_W | Write data |
| rsp_data | output | DATA_W | Captured read beat |
| rsp_valid | output | 1 | One-clock read beat strobe |
| rsp_done | output | 1 | One-clock end-of-access strobe |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_addr | output | ADDR_W | Device address |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_wdata | output | DATA_W | Data to drive onto the bus |
| mem_wdata_en | output | 1 | Bus drive enable for writes |
| mem_rdata | input | DATA_W | Data read from the bus |
| mem_wait_n | input | 1 | Low = variable-latency device not ready |

## Verification
The bench goes after four corner cases.

- **Restart at beat 4 in a group-of-four device.** A design that treats the whole burst as one group shortens beat 4 to N+1 clocks and returns its data early.
- **Release gap across chip selects.** The bench issues requests back to back, switching between different and identical chip selects. A missing gap lets the next chip select fall too soon. An unconditional gap holds `req_ready` low on a repeat access to the same device.
- **Stretched variable-latency strobe.** The bench holds the not-ready input low for several clocks. Sampling it outside the strobe, or ignoring it, moves the capture clock and shortens the address hold.
- **Not-ready on other classes, and long writes.** The bench holds the not-ready input low during a group-of-four read and a class-0 read. It also issues multi-beat writes to burst devices. A design that honours not-ready for every class, or bursts writes, shows extra strobe clocks at the pins.

// File: rtl/srom_pkg.sv
package srom_pkg;
  localparam int TYPE_W = 3;
  localparam int LAT_W  = 4;
  localparam int REC_W  = 3;
  localparam int CFG_W  = TYPE_W + 2 * LAT_W + REC_W;

  localparam logic [TYPE_W-1:0] DEV_PLAIN  = 3'd0;
  localparam logic [TYPE_W-1:0] DEV_GRP4   = 3'd2;
  localparam logic [TYPE_W-1:0] DEV_GRP8   = 3'd3;
  localparam logic [TYPE_W-1:0] DEV_VARLAT = 3'd4;

  // field order fixes the bit layout of each configuration word
  typedef struct packed {
    logic [REC_W-1:0]  recov;
    logic [LAT_W-1:0]  next_lat;
    logic [LAT_W-1:0]  first_lat;
    logic [TYPE_W-1:0] dev;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} seq_state_e;
endpackage

// File: rtl/srom_cfg_sel.sv
module srom_cfg_sel
  import srom_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  input  logic [CS_W-1:0]         sel,
  output cs_cfg_t                 cfg
);
  cs_cfg_t tbl [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign tbl[g] = cfg_words[g*CFG_W +: CFG_W];
  end

  assign cfg = tbl[sel];
endmodule

// File: rtl/srom_beat_lat.sv
module srom_beat_lat
  import srom_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  cs_cfg_t           cfg,
  input  logic [BEAT_W-1:0] beat,
  output logic [LAT_W-1:0]  lat
);
  localparam int GRP_SMALL = 4;
  localparam int GRP_LARGE = 8;

  logic grp4_head;
  logic grp8_head;

  assign grp4_head = (int'(beat) % GRP_SMALL) == 0;
  assign grp8_head = (int'(beat) % GRP_LARGE) == 0;

  always_comb begin
    case (cfg.dev)
      DEV_GRP4: lat = grp4_head ? cfg.first_lat : cfg.next_lat;
      DEV_GRP8: lat = grp8_head ? cfg.first_lat : cfg.next_lat;
      default:  lat = cfg.first_lat;
    endcase
  end
endmodule

// File: rtl/srom_recovery.sv
module srom_recovery
  import srom_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rel_i,
  input  logic [CS_W-1:0]  rel_cs,
  input  logic [REC_W-1:0] rel_len,
  input  logic [CS_W-1:0]  req_cs,
  output logic             ok_o
);
  logic [REC_W-1:0] rec_q;
  logic [CS_W-1:0]  last_q;
  logic             have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q  <= '0;
      last_q <= '0;
      have_q <= 1'b0;
    end else if (rel_i) begin
      rec_q  <= rel_len;
      last_q <= rel_cs;
      have_q <= 1'b1;
    end else if (rec_q != '0) begin
      rec_q <= rec_q - 1'b1;
    end
  end

  assign ok_o = (rec_q == '0) || (have_q && (req_cs == last_q));
endmodule

// File: rtl/srom_seq.sv
module srom_seq
  import srom_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 3,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CS*CFG_W-1:0] cfg_words,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CS_W-1:0]         req_cs,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_valid,
  output logic                    rsp_done,
  output logic [NUM_CS-1:0]       mem_cs_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_oe_n,
  output logic                    mem_we_n,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wdata_en,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_wait_n
);
  localparam logic [NUM_CS-1:0] ONE_HOT0 = NUM_CS'(1);

  seq_state_e       st_q;
  cs_cfg_t          req_cfg;
  cs_cfg_t          cur_cfg;
  logic [CS_W-1:0]  cs_q;
  logic [LEN_W-1:0] beat_q;
  logic [LEN_W-1:0] last_q;
  logic [LEN_W-1:0] beat_nx;
  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W-1:0] nx_lat;
  logic             wr_q;
  logic             vl_q;
  logic             rec_ok;
  logic             accept;
  logic             req_vl;
  logic             win_end;
  logic             fin;

  srom_cfg_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
    .cfg_words (cfg_words),
    .sel       (req_cs),
    .cfg       (req_cfg)
  );

  assign beat_nx = beat_q + 1'b1;

  srom_beat_lat #(.BEAT_W(LEN_W)) u_lat (
    .cfg  (cur_cfg),
    .beat (beat_nx),
    .lat  (nx_lat)
  );

  srom_recovery #(.CS_W(CS_W)) u_rec (
    .clk     (clk),
    .rst     (rst),
    .rel_i   (fin),
    .rel_cs  (cs_q),
    .rel_len (cur_cfg.recov),
    .req_cs  (req_cs),
    .ok_o    (rec_ok)
  );

  assign req_ready = (st_q == ST_IDLE) && rec_ok;
  assign accept    = req_valid && req_ready;
  assign req_vl    = (req_cfg.dev == DEV_VARLAT);

  // the strobe window ends when its count is spent and, for variable-latency parts, the device is ready
  assign win_end = (st_q == ST_STROBE) && (cnt_q == '0) && (!vl_q || mem_wait_n);
  assign fin     = (win_end && !vl_q && (beat_q == last_q)) ||
                   ((st_q == ST_HOLD) && (cnt_q == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      cur_cfg      <= '0;
      cs_q         <= '0;
      beat_q       <= '0;
      last_q       <= '0;
      cnt_q        <= '0;
      wr_q         <= 1'b0;
      vl_q         <= 1'b0;
      rsp_data     <= '0;
      rsp_valid    <= 1'b0;
      rsp_done     <= 1'b0;
      mem_cs_n     <= '1;
      mem_addr     <= '0;
      mem_oe_n     <= 1'b1;
      mem_we_n     <= 1'b1;
      mem_wdata    <= '0;
      mem_wdata_en <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_done  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q         <= ST_STROBE;
            cur_cfg      <= req_cfg;
            cs_q         <= req_cs;
            beat_q       <= '0;
            last_q       <= (req_write || req_vl) ? '0 : req_len;
            cnt_q        <= req_cfg.first_lat;
            wr_q         <= req_write;
            vl_q         <= req_vl;
            mem_cs_n     <= ~(ONE_HOT0 << req_cs);
            mem_addr     <= req_addr;
            mem_oe_n     <= req_write;
            mem_we_n     <= ~req_write;
            mem_wdata    <= req_wdata;
            mem_wdata_en <= req_write;
          end
        end
        ST_STROBE: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (win_end) begin
            if (!wr_q) begin
              rsp_data  <= mem_rdata;
              rsp_valid <= 1'b1;
            end
            if (vl_q) begin
              st_q         <= ST_HOLD;
              mem_oe_n     <= 1'b1;
              mem_we_n     <= 1'b1;
              mem_wdata_en <= 1'b0;
              cnt_q        <= cur_cfg.next_lat;
            end else if (beat_q != last_q) begin
              beat_q   <= beat_nx;
              mem_addr <= mem_addr + 1'b1;
              cnt_q    <= nx_lat;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase

      if (fin) begin
        st_q         <= ST_IDLE;
        mem_cs_n     <= '1;
        mem_oe_n     <= 1'b1;
        mem_we_n     <= 1'b1;
        mem_wdata_en <= 1'b0;
        rsp_done     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/srom_seq_chk.sv
module srom_seq_chk
  import srom_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CS_W   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CS*CFG_W-1:0] cfg_words,
  input logic                    req_ready,
  input logic                    rsp_done,
  input logic [NUM_CS-1:0]       mem_cs_n,
  input logic                    mem_oe_n,
  input logic                    mem_we_n,
  input logic                    mem_wdata_en
);
  logic [7:0]       gap_q;
  logic [CS_W-1:0]  prev_cs_q;
  logic             seen_q;
  logic             all_hi_q;
  logic [CS_W-1:0]  cur_idx;
  logic [REC_W-1:0] prev_rec;
  logic             all_hi;

  assign all_hi = &mem_cs_n;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (!mem_cs_n[i]) cur_idx = CS_W'(i);
    end
  end

  assign prev_rec = cfg_words[int'(prev_cs_q)*CFG_W + (CFG_W - REC_W) +: REC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      prev_cs_q <= '0;
      seen_q    <= 1'b0;
      all_hi_q  <= 1'b1;
    end else begin
      all_hi_q <= all_hi;
      if (all_hi) begin
        if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
      end else begin
        gap_q     <= '0;
        prev_cs_q <= cur_idx;
        seen_q    <= 1'b1;
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (all_hi && mem_oe_n && mem_we_n && req_ready));

  a_r5_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  a_r6_write_drives_bus: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_wdata_en);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  a_r9_done_after_release: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> all_hi);

  a_r12_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> all_hi);

  a_r10_release_gap: assert property (@(posedge clk) disable iff (rst)
    (all_hi_q && !all_hi && seen_q && (cur_idx != prev_cs_q)) |->
      (int'(gap_q) >= int'(prev_rec) + 1));
endmodule

bind srom_seq srom_seq_chk #(
  .NUM_CS (NUM_CS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CS_W   (CS_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_words    (cfg_words),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .mem_cs_n     (mem_cs_n),
  .mem_oe_n     (mem_oe_n),
  .mem_we_n     (mem_we_n),
  .mem_wdata_en (mem_wdata_en)
);

// File: tb/srom_seq_tb_top.sv
module srom_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_CS = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 3;
  localparam int CFG_W  = 14;
  localparam int KEY    = 'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NUM_CS*CFG_W-1:0] cfg_words = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_cs = '0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_valid, rsp_done;
  logic [NUM_CS-1:0] mem_cs_n;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_oe_n, mem_we_n, mem_wdata_en;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_wait_n = 1'b1;

  assign mem_rdata = mem_addr ^ DATA_W'(KEY);

  srom_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_words(cfg_words),
    .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
    .rsp_done(rsp_done), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wdata(mem_wdata),
    .mem_wdata_en(mem_wdata_en), .mem_rdata(mem_rdata), .mem_wait_n(mem_wait_n)
  );

  typedef struct {
    int csn; bit oe_n; bit we_n; bit wen; int wdata;
    bit chk_addr; int addr; bit rv; int rdata; bit rdone;
    bit idle; bit first_idle; bit wn;
  } ent_t;

  ent_t  q[$];
  int    c_dev[NUM_CS], c_f[NUM_CS], c_n[NUM_CS], c_r[NUM_CS];
  int    n_chk = 0, n_fail = 0, cyc = 0;
  int    mrec = 0, mlast = 0, trec = 0, tcs = 0, cur_w = 0;
  bit    mhave = 0, running = 0, idle_wn = 1;
  string cur_tag = "R12";
  string txn_tag = "R12";

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic set_cfg(int i, int dev, int f, int n, int r);
    c_dev[i] = dev; c_f[i] = f; c_n[i] = n; c_r[i] = r;
    cfg_words[i*CFG_W +: CFG_W] = {3'(r), 4'(n), 4'(f), 3'(dev)};
  endtask

  function automatic ent_t mk(int csn, bit oe, bit we, bit wen, int wd, bit ca, int a,
                              bit rv, int rd, bit dn, bit idl, bit fi, bit wn);
    ent_t e;
    e.csn = csn; e.oe_n = oe; e.we_n = we; e.wen = wen; e.wdata = wd;
    e.chk_addr = ca; e.addr = a; e.rv = rv; e.rdata = rd; e.rdone = dn;
    e.idle = idl; e.first_idle = fi; e.wn = wn;
    return e;
  endfunction

  function automatic int beat_lat(int dev, int b, int f, int n);
    if (dev == 2) return (b % 4 == 0) ? f : n;
    if (dev == 3) return (b % 8 == 0) ? f : n;
    return f;
  endfunction

  // expected pin timeline of one access, one entry per clock, from the requirements
  task automatic build(int cs, bit wr, int a, int len, int wd, int w);
    int dev = c_dev[cs];
    int f = c_f[cs];
    int n = c_n[cs];
    int csn = (~(1 << cs)) & 'hF;
    tcs = cs; trec = c_r[cs]; txn_tag = cur_tag;
    if (dev == 4) begin
      for (int k = 0; k < f + 1 + w; k++)
        q.push_back(mk(csn, wr, !wr, wr, wd, 1, a, 0, 0, 0, 0, 0, k >= f + w));
      for (int h = 0; h <= n; h++)
        q.push_back(mk(csn, 1, 1, 0, 0, 1, a, !wr && h == 0, (a ^ KEY) & 'hFFFF, 0, 0, 0, 1));
      q.push_back(mk('hF, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, idle_wn));
    end else if (wr) begin
      for (int k = 0; k <= f; k++)
        q.push_back(mk(csn, 1, 0, 1, wd, 1, a, 0, 0, 0, 0, 0, idle_wn));
      q.push_back(mk('hF, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 1, idle_wn));
    end else begin
      for (int b = 0; b <= len; b++) begin
        for (int i = 0; i <= beat_lat(dev, b, f, n); i++)
          q.push_back(mk(csn, 0, 1, 0, 0, 1, a + b, b > 0 && i == 0,
                         ((a + b - 1) ^ KEY) & 'hFFFF, 0, 0, 0, idle_wn));
      end
      q.push_back(mk('hF, 1, 1, 0, 0, 0, 0, 1, ((a + len) ^ KEY) & 'hFFFF, 1, 1, 1, idle_wn));
    end
  endtask

  // reference model: compared on every clock, at the falling edge
  always @(negedge clk) begin
    if (running) begin
      ent_t e;
      bit   exp_rdy;
      string tg;
      if (q.size() > 0) begin
        e = q.pop_front();
        tg = txn_tag;
      end else begin
        e = mk('hF, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, idle_wn);
        tg = "R12";
      end
      if (e.first_idle) begin
        mrec = trec; mlast = tcs; mhave = 1;
      end else if (e.idle && mrec > 0) begin
        mrec--;
      end
      mem_wait_n = e.wn;
      exp_rdy = e.idle && (mrec == 0 || (mhave && int'(req_cs) == mlast));
      chk(tg, "mem_cs_n", int'(mem_cs_n), e.csn);
      chk(tg, "mem_oe_n", int'(mem_oe_n), int'(e.oe_n));
      chk(tg, "mem_we_n", int'(mem_we_n), int'(e.we_n));
      chk(tg, "mem_wdata_en", int'(mem_wdata_en), int'(e.wen));
      if (e.wen) chk(tg, "mem_wdata", int'(mem_wdata), e.wdata);
      if (e.chk_addr) chk(tg, "mem_addr", int'(mem_addr), e.addr);
      chk(tg, "rsp_valid", int'(rsp_valid), int'(e.rv));
      if (e.rv) chk(tg, "rsp_data", int'(rsp_data), e.rdata);
      chk(tg, "rsp_done", int'(rsp_done), int'(e.rdone));
      chk("R10 R11 R12", "req_ready", int'(req_ready), int'(exp_rdy));
      if (req_valid && exp_rdy)
        build(int'(req_cs), req_write, int'(req_addr), int'(req_len), int'(req_wdata), cur_w);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual %0d cycles expected below 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic req(int cs, bit wr, int a, int len, int wd, int w, string tag);
    @(posedge clk); #1;
    req_cs = 2'(cs); req_write = wr; req_addr = 16'(a); req_len = 3'(len);
    req_wdata = 16'(wd); cur_w = w; cur_tag = tag; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (q.size() != 0);
    repeat (10) @(posedge clk);
  endtask

  initial begin
    set_cfg(0, 0, 2, 5, 1);
    set_cfg(1, 2, 3, 1, 3);
    set_cfg(2, 3, 4, 0, 2);
    set_cfg(3, 4, 1, 2, 2);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset mem_cs_n", int'(mem_cs_n), 'hF);
    chk("R1", "reset strobes", int'({mem_oe_n, mem_we_n}), 3);
    chk("R1", "reset rsp", int'({rsp_valid, rsp_done, mem_wdata_en}), 0);
    chk("R1", "reset req_ready", int'(req_ready), 1);
    running = 1;

    req(0, 0, 'h100, 2, 0, 0, "R2 R5 R9");
    req(1, 0, 'h200, 7, 0, 0, "R3 R5 R9");
    req(1, 0, 'h208, 3, 0, 0, "R11 R3");
    req(0, 0, 'h110, 0, 0, 0, "R10 R2");
    req(2, 0, 'h300, 7, 0, 0, "R4 R5");
    req(2, 0, 'h310, 2, 0, 0, "R4 R11");
    req(1, 1, 'h220, 5, 'hBEEF, 0, "R6");
    req(0, 1, 'h120, 3, 'h1234, 0, "R6 R10");
    req(3, 0, 'h400, 0, 0, 0, "R7 R9");
    req(3, 0, 'h404, 0, 0, 3, "R7");
    req(3, 1, 'h408, 0, 'hCAFE, 2, "R7 R6");
    req(2, 1, 'h320, 7, 'h0F0F, 0, "R6 R10");
    drain();

    idle_wn = 0;
    req(1, 0, 'h230, 5, 0, 0, "R8 R3");
    req(0, 0, 'h130, 1, 0, 0, "R8 R2");
    drain();
    idle_wn = 1;

    set_cfg(0, 5, 1, 7, 0);
    req(0, 0, 'h140, 2, 0, 0, "R2");
    req(1, 0, 'h240, 0, 0, 0, "R10 R3");
    drain();
    set_cfg(0, 7, 0, 3, 0);
    req(0, 0, 'h150, 3, 0, 0, "R2 R5");
    req(3, 0, 'h410, 0, 0, 1, "R7 R10");
    drain();

    running = 0;
    summary();
    $finish;
  end
endmodule